// File: doc/BRIEF.md
# Ping-Pong Synthesizer Hop Controller

This block sequences a frequency-agile source built from two identical, slow-settling phase-locked loops and one fast output selector. A loop takes tens of milliseconds to lock after it is retuned. The controller therefore keeps one loop on the output while it retunes the other in the background. On each hop request it flips the selector to the loop that was tuned during the interval just ended. It then reprograms the loop it has just released with the next entry of a circular hop schedule. Hop time is set by the selector and not by loop acquisition.

Each schedule entry holds a 24-bit divider word and a filter-bank index. In the divider word, bits [23:16] carry the integer feedback term and bits [15:0] carry the fractional numerator. The controller sends the word unchanged over a three-wire serial link (bit clock, data, and one latch enable per loop). It also counts down a programmable settle window for each loop. It drives the select lines of the post-mixer filter bank so that they always match the loop on the output. If the host hops onto a loop whose settle window has not yet run out, the hop still takes place and a sticky error flag is raised.

The host fills the schedule table, sets the schedule length and the settle window, and then raises `run`. After that it issues one-cycle hop requests.

Top module: `hop_pingpong_ctrl`

## Requirements
- R1: While reset is held, and until `run` is raised, `sel_b` is 0 (loop A on the output), and `prog_busy`, `hop_err`, `ser_le`, `loop_rdy` and `filt_sel` are all 0.
- R2: After `run` rises, loop A is written with table entry 0 and then loop B with table entry 1. Each word is 24 bits, sent MSB first, one bit every two clock cycles. `ser_dat` is valid on the rising edge of `ser_clk`.
- R3: `loop_rdy[k]` is low while loop k is being written. It rises exactly `settle_cycles` clock cycles after `prog_busy` falls at the end of that write, and it stays high until loop k is written again.
- R4: A hop request has no effect on `sel_b` in three cases: before the start-up writes are done, before loop A has reported ready once, or while `prog_busy` is high.
- R5: An accepted hop toggles `sel_b` at the next clock edge. In that same cycle, `filt_sel` shows the filter index of the entry that was loaded into the loop now on the output.
- R6: An accepted hop starts a write of the released loop. `prog_busy` is high in the cycle after the hop. Entries are taken in table order from index 2 on, and index 0 follows index `sched_len`-1.
- R7: A hop onto a loop whose `loop_rdy` is low still toggles `sel_b` and sets `hop_err`. `hop_err` stays set until a cycle with `err_clr` high. A new error in the same cycle as `err_clr` leaves the flag set.
- R8: Each write ends with a one-cycle latch pulse: `ser_le[0]` for loop A, `ser_le[1]` for loop B, never both. `prog_busy` falls in the cycle after the latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Starts the start-up writes of both loops |
| tbl_we | input | 1 | Schedule table write strobe |
| tbl_addr | input | $clog2(DEPTH) | Schedule table write index |
| tbl_word | input | 24 | Divider word to store ([23:16] integer, [15:0] fraction) |
| tbl_filt | input | FW | Filter-bank index to store |
| sched_len | input | $clog2(DEPTH+1) | Number of schedule entries in use (2..DEPTH) |
| settle_cycles | input | CNT_W | Settle window per loop, in clock cycles |
| hop_req | input | 1 | One-cycle hop request |
| err_clr | input | 1 | Clears the sticky hop error |
| sel_b | output | 1 | Output selector: 0 loop A, 1 loop B |
| filt_sel | output | FW | Filter-bank select for the active frequency |
| loop_rdy | output | 2 | Per-loop settled flag, bit 0 loop A |
| prog_busy | output | 1 | A serial write is in progress |
| hop_err | output | 1 | Sticky flag: a hop landed on an unsettled loop |
| ser_clk | output | 1 | Serial bit clock |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_le | output | 2 | Latch enables, bit 0 loop A, bit 1 loop B |

## Verification
The assertions assume the following about the inputs. No write is started while one is still in flight. `settle_cycles` and `sched_len` stay constant once `run` is high. `sched_len` is at least 2. The bench keeps to this: it fills the table and sets a length of 3 and a settle window of 80 cycles before raising `run`, and it never changes them afterwards. It issues hop requests only as single-cycle pulses. It also places some of them deliberately inside a write, or onto a loop that has not settled, so that the ignore path and the error path are both driven.

// File: rtl/hop_pkg.sv
package hop_pkg;

  localparam int WORD_W = 24;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_INIT_A,
    SQ_WAIT_A,
    SQ_INIT_B,
    SQ_WAIT_B,
    SQ_RUN
  } seq_state_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_SHIFT,
    WR_LATCH
  } wr_state_t;

endpackage

// File: rtl/hop_schedule_table.sv
module hop_schedule_table #(
  parameter int DEPTH  = 8,
  parameter int FW     = 3,
  parameter int WORD_W = 24
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WORD_W-1:0]        wword,
  input  logic [FW-1:0]            wfilt,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WORD_W-1:0]        rword,
  output logic [FW-1:0]            rfilt
);

  localparam int ENT_W = WORD_W + FW;

  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= {wfilt, wword};
    end
  end

  assign rword = mem_q[raddr][WORD_W-1:0];
  assign rfilt = mem_q[raddr][ENT_W-1:WORD_W];

endmodule

// File: rtl/hop_serial_writer.sv
module hop_serial_writer
  import hop_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tgt,
  input  logic [W-1:0] word,
  output logic         busy,
  output logic         cur_tgt,
  output logic         ser_clk,
  output logic         ser_dat,
  output logic [1:0]   ser_le
);

  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  wr_state_t        st_q, st_d;
  logic [W-1:0]     sr_q, sr_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             ph_q, ph_d;
  logic             tgt_q, tgt_d;

  always_comb begin
    st_d  = st_q;
    sr_d  = sr_q;
    bit_d = bit_q;
    ph_d  = ph_q;
    tgt_d = tgt_q;
    case (st_q)
      WR_IDLE: begin
        if (start) begin
          st_d  = WR_SHIFT;
          sr_d  = word;
          bit_d = '0;
          ph_d  = 1'b0;
          tgt_d = tgt;
        end
      end
      WR_SHIFT: begin
        ph_d = ~ph_q;
        if (ph_q) begin
          sr_d = {sr_q[W-2:0], 1'b0};
          if (bit_q == LAST_BIT) begin
            st_d = WR_LATCH;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      WR_LATCH: st_d = WR_IDLE;
      default:  st_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WR_IDLE;
      sr_q  <= '0;
      bit_q <= '0;
      ph_q  <= 1'b0;
      tgt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sr_q  <= sr_d;
      bit_q <= bit_d;
      ph_q  <= ph_d;
      tgt_q <= tgt_d;
    end
  end

  assign busy    = (st_q != WR_IDLE);
  assign cur_tgt = tgt_q;
  assign ser_clk = (st_q == WR_SHIFT) && ph_q;
  assign ser_dat = (st_q == WR_SHIFT) && sr_q[W-1];
  assign ser_le  = (st_q == WR_LATCH) ? (tgt_q ? 2'b10 : 2'b01) : 2'b00;

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ser_le != 2'b00));

  // R8
  le_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_le != 2'b00) |=> (ser_le == 2'b00));

endmodule

// File: rtl/hop_settle_timer.sv
module hop_settle_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             ready
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;

  always_comb begin
    cnt_d   = cnt_q;
    valid_d = valid_q;
    if (hold) begin
      cnt_d   = settle_cycles;
      valid_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign ready = valid_q && !hold && (cnt_q == '0);

  // R3
  rdy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (ready || hold));

endmodule

// File: rtl/hop_sequencer.sv
module hop_sequencer
  import hop_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 4,
  parameter int FW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hop_req,
  input  logic             err_clr,
  input  logic [LEN_W-1:0] sched_len,
  input  logic             wr_busy,
  input  logic [1:0]       loop_rdy,
  input  logic [FW-1:0]    rd_filt,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_start,
  output logic             wr_tgt,
  output logic             sel_b,
  output logic [FW-1:0]    filt_sel,
  output logic             hop_err
);

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sel_q, sel_d;
  logic             armed_q, armed_d;
  logic             err_q, err_d;
  logic [FW-1:0]    filt_a_q, filt_a_d;
  logic [FW-1:0]    filt_b_q, filt_b_d;
  logic             hop_ok;
  logic             tgt_rdy;
  logic [LEN_W-1:0] idx_inc;

  assign tgt_rdy  = sel_q ? loop_rdy[0] : loop_rdy[1];
  assign hop_ok   = (st_q == SQ_RUN) && armed_q && !wr_busy && hop_req;
  assign wr_start = (st_q == SQ_INIT_A) || (st_q == SQ_INIT_B) || hop_ok;
  assign wr_tgt   = (st_q == SQ_RUN) ? sel_q : (st_q == SQ_INIT_B);
  assign idx_inc  = LEN_W'(idx_q) + 1'b1;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    sel_d    = sel_q;
    armed_d  = armed_q;
    err_d    = err_q;
    filt_a_d = filt_a_q;
    filt_b_d = filt_b_q;
    case (st_q)
      SQ_IDLE:   if (run) st_d = SQ_INIT_A;
      SQ_INIT_A: st_d = SQ_WAIT_A;
      SQ_WAIT_A: if (!wr_busy) st_d = SQ_INIT_B;
      SQ_INIT_B: st_d = SQ_WAIT_B;
      SQ_WAIT_B: if (!wr_busy) st_d = SQ_RUN;
      SQ_RUN:    if (loop_rdy[0]) armed_d = 1'b1;
      default:   st_d = SQ_IDLE;
    endcase
    if (wr_start) begin
      idx_d = (idx_inc >= sched_len) ? '0 : IDX_W'(idx_inc);
      if (wr_tgt) filt_b_d = rd_filt;
      else        filt_a_d = rd_filt;
    end
    if (hop_ok) begin
      sel_d = ~sel_q;
    end
    if (hop_ok && !tgt_rdy) begin
      err_d = 1'b1;
    end else if (err_clr) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      idx_q    <= '0;
      sel_q    <= 1'b0;
      armed_q  <= 1'b0;
      err_q    <= 1'b0;
      filt_a_q <= '0;
      filt_b_q <= '0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      sel_q    <= sel_d;
      armed_q  <= armed_d;
      err_q    <= err_d;
      filt_a_q <= filt_a_d;
      filt_b_q <= filt_b_d;
    end
  end

  assign rd_idx   = idx_q;
  assign sel_b    = sel_q;
  assign hop_err  = err_q;
  assign filt_sel = sel_q ? filt_b_q : filt_a_q;

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_b) |-> ($past(hop_req) && !$past(wr_busy)));

  // R6
  hop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_b) |-> wr_busy);

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hop_err) |-> $past(hop_req));

  // R7
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_err && !err_clr) |=> hop_err);

endmodule

// File: rtl/hop_pingpong_ctrl.sv
module hop_pingpong_ctrl
  import hop_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int FW    = 3,
  parameter int CNT_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       tbl_we,
  input  logic [$clog2(DEPTH)-1:0]   tbl_addr,
  input  logic [23:0]                tbl_word,
  input  logic [FW-1:0]              tbl_filt,
  input  logic [$clog2(DEPTH+1)-1:0] sched_len,
  input  logic [CNT_W-1:0]           settle_cycles,
  input  logic                       hop_req,
  input  logic                       err_clr,
  output logic                       sel_b,
  output logic [FW-1:0]              filt_sel,
  output logic [1:0]                 loop_rdy,
  output logic                       prog_busy,
  output logic                       hop_err,
  output logic                       ser_clk,
  output logic                       ser_dat,
  output logic [1:0]                 ser_le
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic [FW-1:0]     rd_filt;
  logic              wr_start;
  logic              wr_tgt;
  logic              wr_busy;
  logic              wr_cur_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  hop_schedule_table #(.DEPTH(DEPTH), .FW(FW), .WORD_W(WORD_W)) i_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wword (tbl_word),
    .wfilt (tbl_filt),
    .raddr (rd_idx),
    .rword (rd_word),
    .rfilt (rd_filt)
  );

  hop_sequencer #(.IDX_W(IDX_W), .LEN_W(LEN_W), .FW(FW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .hop_req   (hop_req),
    .err_clr   (err_clr),
    .sched_len (sched_len),
    .wr_busy   (wr_busy),
    .loop_rdy  (loop_rdy),
    .rd_filt   (rd_filt),
    .rd_idx    (rd_idx),
    .wr_start  (wr_start),
    .wr_tgt    (wr_tgt),
    .sel_b     (sel_b),
    .filt_sel  (filt_sel),
    .hop_err   (hop_err)
  );

  hop_serial_writer #(.W(WORD_W)) i_writer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (wr_start),
    .tgt     (wr_tgt),
    .word    (rd_word),
    .busy    (wr_busy),
    .cur_tgt (wr_cur_tgt),
    .ser_clk (ser_clk),
    .ser_dat (ser_dat),
    .ser_le  (ser_le)
  );

  for (genvar k = 0; k < 2; k++) begin : g_loop
    hop_settle_timer #(.CNT_W(CNT_W)) i_timer (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .hold          (wr_busy && (wr_cur_tgt == 1'(k))),
      .settle_cycles (settle_cycles),
      .ready         (loop_rdy[k])
    );
  end

  assign prog_busy = wr_busy;

endmodule

// File: tb/test_hop_pingpong_ctrl.sv
`timescale 1ns/1ps
module test_hop_pingpong_ctrl;

  localparam int DEPTH  = 8;
  localparam int FW     = 3;
  localparam int CNT_W  = 24;
  localparam int SETTLE = 80;
  localparam int LEN    = 3;
  localparam int N_HOPS = 5;

  // schedule vectors: {filter index, divider word}
  localparam logic [26:0] SCHED [4] = '{
    {3'd5, 24'h1A2B3C},
    {3'd2, 24'h0F00F1},
    {3'd7, 24'hC35A96},
    {3'd1, 24'h800001}
  };

  logic clk = 1'b0;
  logic rst_n, run, tbl_we, hop_req, err_clr;
  logic [2:0] tbl_addr;
  logic [23:0] tbl_word;
  logic [FW-1:0] tbl_filt;
  logic [3:0] sched_len;
  logic [CNT_W-1:0] settle_cycles;
  logic sel_b, prog_busy, hop_err, ser_clk, ser_dat;
  logic [FW-1:0] filt_sel;
  logic [1:0] loop_rdy, ser_le;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hop_pingpong_ctrl #(.DEPTH(DEPTH), .FW(FW), .CNT_W(CNT_W)) i_hop_pingpong_ctrl (
    .clk, .rst_n, .run, .tbl_we, .tbl_addr, .tbl_word, .tbl_filt,
    .sched_len, .settle_cycles, .hop_req, .err_clr,
    .sel_b, .filt_sel, .loop_rdy, .prog_busy, .hop_err,
    .ser_clk, .ser_dat, .ser_le
  );

  // serial link monitor
  logic        prev_sclk = 1'b0;
  logic [23:0] shreg = '0;
  logic [23:0] log_word [64];
  logic        log_loop [64];
  int          log_n = 0;

  always @(negedge clk) begin
    if (ser_clk && !prev_sclk) shreg <= {shreg[22:0], ser_dat};
    if (ser_le != 2'b00 && log_n < 64) begin
      log_word[log_n] <= shreg;
      log_loop[log_n] <= ser_le[1];
      log_n <= log_n + 1;
    end
    prev_sclk <= ser_clk;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hop_pulse(input logic clr);
    @(negedge clk);
    hop_req = 1'b1;
    err_clr = clr;
    @(negedge clk);
    hop_req = 1'b0;
    err_clr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (prog_busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  int  m_idx;
  logic m_sel;
  int  loop_entry [2];
  int  n;

  initial begin
    rst_n = 1'b0; run = 1'b0; tbl_we = 1'b0; hop_req = 1'b0; err_clr = 1'b0;
    tbl_addr = '0; tbl_word = '0; tbl_filt = '0;
    sched_len = 4'(LEN); settle_cycles = CNT_W'(SETTLE);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sel_b, 0, "R1 sel_b");
    chk(prog_busy, 0, "R1 prog_busy");
    chk(hop_err, 0, "R1 hop_err");
    chk(ser_le, 0, "R1 ser_le");
    chk(loop_rdy, 0, "R1 loop_rdy");
    chk(filt_sel, 0, "R1 filt_sel");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      tbl_we = 1'b1; tbl_addr = 3'(i);
      tbl_word = SCHED[i][23:0]; tbl_filt = SCHED[i][26:24];
      @(negedge clk);
    end
    tbl_we = 1'b0;
    chk(loop_rdy, 0, "R1 loop_rdy before run");

    // start-up, with a hop request that must be ignored (R4)
    run = 1'b1; hop_req = 1'b1;
    @(negedge clk);
    hop_req = 1'b0;
    @(negedge clk);
    chk(sel_b, 0, "R4 hop before start-up done");
    while (prog_busy || log_n < 2) @(negedge clk);
    chk(log_n, 2, "R2 start-up write count");
    chk(log_loop[0], 0, "R2 first write loop A");
    chk(log_word[0], SCHED[0][23:0], "R2 loop A word");
    chk(log_loop[1], 1, "R2 second write loop B");
    chk(log_word[1], SCHED[1][23:0], "R2 loop B word");
    chk(loop_rdy[0], 0, "R4 loop A not yet settled");
    // hop while loop A not settled: ignored (R4)
    hop_req = 1'b1;
    @(negedge clk);
    hop_req = 1'b0;
    @(negedge clk);
    chk(sel_b, 0, "R4 hop before loop A ready");
    chk(loop_rdy[1], 0, "R3 loop B low early");
    n = 2;
    while (!loop_rdy[1] && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n, SETTLE, "R3 settle window length");
    while (!loop_rdy[0]) @(negedge clk);
    @(negedge clk);

    m_idx = 2; m_sel = 1'b0; loop_entry[0] = 0; loop_entry[1] = 1;
    chk(filt_sel, SCHED[0][26:24], "R5 filter after start-up");

    // vector walk: settled hops
    for (int h = 0; h < N_HOPS; h++) begin
      while (!(loop_rdy[!m_sel] && !prog_busy)) @(negedge clk);
      hop_pulse(1'b0);
      m_sel = !m_sel;
      loop_entry[!m_sel] = m_idx;
      chk(sel_b, m_sel, "R5 selector toggles");
      chk(filt_sel, SCHED[loop_entry[m_sel]][26:24], "R5 filter follows");
      chk(hop_err, 0, "R7 no error on settled hop");
      chk(prog_busy, 1, "R6 write starts after hop");
      wait_idle();
      chk(log_word[log_n-1], SCHED[m_idx][23:0], "R6 next entry word");
      chk(log_loop[log_n-1], !m_sel, "R8 latch on released loop");
      m_idx = (m_idx + 1) % LEN;
    end

    // R7 hop onto unsettled loop
    hop_pulse(1'b0);
    m_sel = !m_sel;
    loop_entry[!m_sel] = m_idx;
    chk(sel_b, m_sel, "R7 switch still happens");
    chk(hop_err, 1, "R7 error set");
    chk(filt_sel, SCHED[loop_entry[m_sel]][26:24], "R5 filter on error hop");
    hop_pulse(1'b0);
    chk(sel_b, m_sel, "R4 hop ignored while busy");
    wait_idle();
    chk(log_word[log_n-1], SCHED[m_idx][23:0], "R6 wrap entry word");
    m_idx = (m_idx + 1) % LEN;
    repeat (5) @(negedge clk);
    chk(hop_err, 1, "R7 error sticky");
    // set and clear together: set wins
    hop_pulse(1'b1);
    m_sel = !m_sel;
    chk(sel_b, m_sel, "R7 switch with clear");
    chk(hop_err, 1, "R7 set beats clear");
    wait_idle();
    chk(log_word[log_n-1], SCHED[m_idx][23:0], "R6 entry after wrap");
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(hop_err, 0, "R7 error cleared");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule